// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor core built around a single accumulator. It runs single-word instructions from a synchronous, word-addressed memory. Every memory access goes through a dedicated address-holding register and a dedicated data-buffer register. Each of these two registers has its own source multiplexer. As a result, each instruction moves through a fixed series of register-transfer states: a fetch phase, a decode step and an execute sequence chosen by the opcode.

An instruction word carries the opcode in its upper bits and a direct memory address in its lower bits. The core loads, stores, adds and jumps. It treats every opcode it does not define as a no-op, and it stops on a halt opcode until the next reset.

The memory is outside the block. It takes the address and write data from the core, writes when the write strobe is high, and returns read data one clock after it sees an address. The accumulator and program counter are brought out so that the surrounding logic can observe progress.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low and on the first cycle after it is released, the program counter and accumulator read 0, halted is 0 and the write strobe is 0.
- R2: An instruction word is 16 bits. Bits [15:12] are the opcode and bits [11:0] are the operand address X. The program counter advances by exactly one for every instruction fetched.
- R3: Opcode 1 (load) sets the accumulator to the memory word at X.
- R4: Opcode 2 (store) writes the accumulator to memory word X. The write strobe is high for exactly one cycle, and during that cycle the write data equals the accumulator and the address equals X.
- R5: Opcode 3 (add) sets the accumulator to the accumulator plus the word at X, modulo 2^16.
- R6: Opcode 4 (jump) loads X into the program counter, so the next instruction is fetched from X.
- R7: Opcodes 5 to 15 change neither the accumulator nor memory. Only the program counter advance of R2 applies.
- R8: Opcode 0 (halt) raises halted one cycle after decode. Halted then stays high until reset, with the program counter and accumulator frozen and no memory write.
- R9: Timing in clock cycles. Fetch plus decode takes 5 cycles. Load and add take 9 cycles each, store takes 8 and jump takes 6. Halt and the no-op opcodes take 5. Read data is taken one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address (held in the address register) |
| mem_wdata | output | 16 | Memory write data (held in the data-buffer register) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High while the core is stopped by a halt opcode |
| pc_out | output | 12 | Current program counter |
| acc_out | output | 16 | Current accumulator |

## Verification
The bench aims at several corner cases, and each one has a distinct symptom if the design gets it wrong:

- **Read latency.** An add whose sum wraps past 0xFFFF would give a saturated or carry-polluted accumulator if the adder were wrong. A core that took read data one cycle early would load the previous word instead of the word at X.
- **Store path.** A store followed at once by a load of the same address shows whether the buffer register was sourced from the accumulator. A wrong buffer source writes the stale fetched instruction word into memory.
- **Jump.** A jump that skips over a load and a halt shows whether the program counter is overwritten rather than incremented.
- **Undefined opcodes.** Runs of opcodes 5 to 15 must leave the accumulator and memory alone.
- **Cycle counts.** The total cycle count of every program is compared with the per-opcode state counts. A missing or extra state shows up as a count mismatch even when the data results are right.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_HALT  = 4'd0,
      OP_LOAD  = 4'd1,
      OP_STORE = 4'd2,
      OP_ADD   = 4'd3,
      OP_JUMP  = 4'd4
   } opcode_e;

   typedef enum logic [3:0] {
      ST_F_ADDR,
      ST_F_READ,
      ST_F_LOAD,
      ST_F_IR,
      ST_DECODE,
      ST_X_ADDR,
      ST_X_READ,
      ST_X_LOAD,
      ST_X_ACC,
      ST_S_BUF,
      ST_S_WRITE,
      ST_J_PC,
      ST_HALTED
   } state_e;

   typedef enum logic {
      ADR_FROM_PC = 1'b0,
      ADR_FROM_IR = 1'b1
   } mar_src_e;

   typedef enum logic {
      BUF_FROM_MEM = 1'b0,
      BUF_FROM_ACC = 1'b1
   } mbr_src_e;

   typedef enum logic {
      ACC_FROM_BUF = 1'b0,
      ACC_FROM_ALU = 1'b1
   } acc_src_e;

   typedef struct packed {
      logic     mar_ld;
      mar_src_e mar_sel;
      logic     mbr_ld;
      mbr_src_e mbr_sel;
      logic     ir_ld;
      logic     pc_inc;
      logic     pc_jump;
      logic     acc_ld;
      acc_src_e acc_sel;
      logic     mem_we;
      logic     halted;
   } ctrl_t;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   output ctrl_t            ctrl
);

   state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_F_ADDR;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_F_ADDR:  state_d = ST_F_READ;
         ST_F_READ:  state_d = ST_F_LOAD;
         ST_F_LOAD:  state_d = ST_F_IR;
         ST_F_IR:    state_d = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OP_HALT:  state_d = ST_HALTED;
               OP_LOAD,
               OP_STORE,
               OP_ADD:   state_d = ST_X_ADDR;
               OP_JUMP:  state_d = ST_J_PC;
               default:  state_d = ST_F_ADDR;
            endcase
         end
         ST_X_ADDR:  state_d = (opcode == OP_STORE) ? ST_S_BUF : ST_X_READ;
         ST_X_READ:  state_d = ST_X_LOAD;
         ST_X_LOAD:  state_d = ST_X_ACC;
         ST_X_ACC:   state_d = ST_F_ADDR;
         ST_S_BUF:   state_d = ST_S_WRITE;
         ST_S_WRITE: state_d = ST_F_ADDR;
         ST_J_PC:    state_d = ST_F_ADDR;
         ST_HALTED:  state_d = ST_HALTED;
         default:    state_d = ST_F_ADDR;
      endcase
   end

   always_comb begin
      ctrl = '0;
      ctrl.mar_sel = ADR_FROM_PC;
      ctrl.mbr_sel = BUF_FROM_MEM;
      ctrl.acc_sel = ACC_FROM_BUF;
      unique case (state_q)
         ST_F_ADDR: begin
            ctrl.mar_ld  = 1'b1;
            ctrl.mar_sel = ADR_FROM_PC;
            ctrl.pc_inc  = 1'b1;
         end
         ST_F_LOAD: begin
            ctrl.mbr_ld  = 1'b1;
            ctrl.mbr_sel = BUF_FROM_MEM;
         end
         ST_F_IR:   ctrl.ir_ld = 1'b1;
         ST_X_ADDR: begin
            ctrl.mar_ld  = 1'b1;
            ctrl.mar_sel = ADR_FROM_IR;
         end
         ST_X_LOAD: begin
            ctrl.mbr_ld  = 1'b1;
            ctrl.mbr_sel = BUF_FROM_MEM;
         end
         ST_X_ACC: begin
            ctrl.acc_ld  = 1'b1;
            ctrl.acc_sel = (opcode == OP_ADD) ? ACC_FROM_ALU : ACC_FROM_BUF;
         end
         ST_S_BUF: begin
            ctrl.mbr_ld  = 1'b1;
            ctrl.mbr_sel = BUF_FROM_ACC;
         end
         ST_S_WRITE: ctrl.mem_we  = 1'b1;
         ST_J_PC:    ctrl.pc_jump = 1'b1;
         ST_HALTED:  ctrl.halted  = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int DATA_W       = 16,
   parameter bit ADD_SATURATE = 1'b0
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] sum
);

   logic [DATA_W:0] wide_sum;

   assign wide_sum = {1'b0, lhs} + {1'b0, rhs};

   generate
      if (ADD_SATURATE) begin : g_sat
         assign sum = wide_sum[DATA_W] ? {DATA_W{1'b1}} : wide_sum[DATA_W-1:0];
      end else begin : g_wrap
         assign sum = wide_sum[DATA_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             ctrl,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] alu_sum,
   output logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] acc
);

   logic [DATA_W-1:0] ir_q;
   logic [ADDR_W-1:0] oper_addr;
   logic [ADDR_W-1:0] mar_in;
   logic [DATA_W-1:0] mbr_in;
   logic [DATA_W-1:0] acc_in;

   assign opcode    = ir_q[DATA_W-1 -: OPC_W];
   assign oper_addr = ir_q[ADDR_W-1:0];

   assign mar_in = (ctrl.mar_sel == ADR_FROM_IR) ? oper_addr : pc;
   assign mbr_in = (ctrl.mbr_sel == BUF_FROM_ACC) ? acc : mem_rdata;
   assign acc_in = (ctrl.acc_sel == ACC_FROM_ALU) ? alu_sum : mbr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc   <= '0;
         acc  <= '0;
         mar  <= '0;
         mbr  <= '0;
         ir_q <= '0;
      end else begin
         if (ctrl.pc_jump)     pc   <= oper_addr;
         else if (ctrl.pc_inc) pc   <= pc + ADDR_W'(1);
         if (ctrl.mar_ld)      mar  <= mar_in;
         if (ctrl.mbr_ld)      mbr  <= mbr_in;
         if (ctrl.ir_ld)       ir_q <= mbr;
         if (ctrl.acc_ld)      acc  <= acc_in;
      end
   end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit ADD_SATURATE = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   output logic [DATA_W-OPC_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]           mem_wdata,
   output logic                        mem_we,
   input  logic [DATA_W-1:0]           mem_rdata,
   output logic                        halted,
   output logic [DATA_W-OPC_W-1:0]     pc_out,
   output logic [DATA_W-1:0]           acc_out
);

   localparam int ADDR_W = DATA_W - OPC_W;

   generate
      if (DATA_W <= OPC_W + 1) begin : g_bad_width
         $error("acc_cpu_core: DATA_W must leave room for an address field");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [OPC_W-1:0]  opcode;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] mbr;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] alu_sum;

   acc_cpu_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .ctrl   (ctrl)
   );

   acc_cpu_datapath #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .mem_rdata (mem_rdata),
      .alu_sum   (alu_sum),
      .opcode    (opcode),
      .mar       (mar),
      .mbr       (mbr),
      .pc        (pc),
      .acc       (acc)
   );

   acc_cpu_alu #(
      .DATA_W       (DATA_W),
      .ADD_SATURATE (ADD_SATURATE)
   ) u_alu (
      .lhs (acc),
      .rhs (mbr),
      .sum (alu_sum)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_we    = ctrl.mem_we;
   assign halted    = ctrl.halted;
   assign pc_out    = pc;
   assign acc_out   = acc;

endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_we,
   input logic              halted,
   input logic [ADDR_W-1:0] pc_out,
   input logic [DATA_W-1:0] acc_out
);

   logic seen_rst;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_rst <= 1'b1;
   end

   a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_rst === 1'b1 && $rose(rst_n)) |-> (pc_out == '0 && acc_out == '0 && !halted && !mem_we));

   a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   a_r4_write_data_is_acc: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == acc_out));

   a_r4_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(rst_n)) |-> $stable(mem_addr));

   a_r8_halt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && $past(halted)) |-> ($stable(pc_out) && $stable(acc_out) && !mem_we));

endmodule

bind acc_cpu_core acc_cpu_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (DATA_W - acc_cpu_pkg::OPC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_we    (mem_we),
   .halted    (halted),
   .pc_out    (pc_out),
   .acc_out   (acc_out)
);

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata;
   logic        halted;
   logic [11:0] pc_out;
   logic [15:0] acc_out;

   int checks = 0;
   int failures = 0;

   logic [15:0] mem     [256];
   logic [15:0] ref_mem [256];

   always #10 clk = ~clk;

   acc_cpu_core u_acc_cpu_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .halted    (halted),
      .pc_out    (pc_out),
      .acc_out   (acc_out)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   function automatic logic [15:0] instr(int op, int x);
      return {4'(op), 12'(x)};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         mem[i] = '0;
         ref_mem[i] = '0;
      end
   endtask

   task automatic put(int a, logic [15:0] v);
      mem[a] = v;
      ref_mem[a] = v;
   endtask

   // Reference interpreter working on ref_mem
   task automatic ref_run(output logic [15:0] a, output logic [11:0] pc, output int cyc);
      logic [15:0] w;
      logic [11:0] x;
      a = '0; pc = '0; cyc = 0;
      for (int s = 0; s < 2000; s++) begin
         w = ref_mem[pc[7:0]];
         x = w[11:0];
         pc = pc + 12'd1;
         case (w[15:12])
            4'd0: begin cyc += 5; return; end
            4'd1: begin a = ref_mem[x[7:0]]; cyc += 9; end
            4'd2: begin ref_mem[x[7:0]] = a; cyc += 8; end
            4'd3: begin a = a + ref_mem[x[7:0]]; cyc += 9; end
            4'd4: begin pc = x; cyc += 6; end
            default: cyc += 5;
         endcase
      end
   endtask

   task automatic run_program(string req);
      logic [15:0] exp_a;
      logic [11:0] exp_pc;
      int          exp_cyc;
      int          cyc;
      int          bad;
      ref_run(exp_a, exp_pc, exp_cyc);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "reset pc", 32'(pc_out), 32'h0);
      check("R1", "reset acc", 32'(acc_out), 32'h0);
      check("R1", "reset halted/we", {30'b0, halted, mem_we}, 32'h0);
      rst_n = 1'b1;
      cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (halted) break;
      end
      check(req, "accumulator", 32'(acc_out), 32'(exp_a));
      check("R2", "program counter", 32'(pc_out), 32'(exp_pc));
      check("R9", "cycles to halt", 32'(cyc), 32'(exp_cyc));
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
      check(req, "memory mismatches", 32'(bad), 32'h0);
      repeat (4) @(negedge clk);
      check("R8", "halt held", {31'b0, halted}, 32'h1);
      check("R8", "pc frozen", 32'(pc_out), 32'(exp_pc));
      check("R8", "acc frozen", 32'(acc_out), 32'(exp_a));
   endtask

   task automatic random_program();
      int len;
      int r;
      clear_mem();
      len = 6 + int'($urandom % 15);
      for (int a = 128; a < 160; a++) put(a, 16'($urandom));
      for (int p = 0; p < len; p++) begin
         r = int'($urandom % 8);
         case (r)
            0, 1: put(p, instr(1, 128 + int'($urandom % 32)));
            2:    put(p, instr(2, 128 + int'($urandom % 32)));
            3, 4: put(p, instr(3, 128 + int'($urandom % 32)));
            5:    put(p, instr(4, (p + 2 <= len) ? p + 2 : len));
            default: put(p, instr(5 + int'($urandom % 11), int'($urandom % 4096)));
         endcase
      end
      put(len, instr(0, 0));
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=expired expected=halt");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R3: plain load
      clear_mem();
      put(0, instr(1, 130)); put(1, instr(0, 0)); put(130, 16'hBEEF);
      run_program("R3");
      check("R3", "load value", 32'(acc_out), 32'h0000BEEF);

      // R4: load, store, reload through the stored word
      clear_mem();
      put(0, instr(1, 130)); put(1, instr(2, 131)); put(2, instr(3, 131));
      put(3, instr(0, 0)); put(130, 16'h1234);
      run_program("R4");
      check("R4", "stored word", 32'(mem[131]), 32'h00001234);
      check("R4", "store then add", 32'(acc_out), 32'h00002468);

      // R5: add wraps past the top
      clear_mem();
      put(0, instr(1, 130)); put(1, instr(3, 131)); put(2, instr(0, 0));
      put(130, 16'hFFFF); put(131, 16'h0002);
      run_program("R5");
      check("R5", "wrapped sum", 32'(acc_out), 32'h1);

      // R6: jump over a load and a halt
      clear_mem();
      put(0, instr(4, 3)); put(1, instr(1, 130)); put(2, instr(0, 0));
      put(3, instr(0, 0)); put(130, 16'h5555);
      run_program("R6");
      check("R6", "pc after jump", 32'(pc_out), 32'h4);

      // R7: every undefined opcode in a row
      clear_mem();
      put(0, instr(1, 130)); put(130, 16'h0F0F);
      for (int k = 5; k < 16; k++) put(k - 4, instr(k, 131));
      put(12, instr(0, 0));
      run_program("R7");
      check("R7", "acc after no-ops", 32'(acc_out), 32'h00000F0F);

      for (int t = 0; t < 12; t++) begin
         random_program();
         run_program("R2");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule